// File: doc/BRIEF.md
# Host-Port Access Sequencer

This block is a bus master for the byte-wide host port of a signal processor. A host side issues single-word commands (read or write, 16-bit address, 16-bit data) over a valid/ready interface. The block turns each command into a fixed script of byte cycles on the port. It drives an active-low chip select, a two-bit register select, a byte-half flag, active-low read and write strobes and an outgoing data byte, and it takes an incoming data byte. Every 16-bit register access is two byte cycles. The byte-half flag is 0 on the first cycle and 1 on the second.

After reset the block programs the processor's control register once. This write clears the interrupt the processor raised while booting and sets the byte-order bit. Until that write completes, commands are held off. Each accepted command waits for a qualified data-ready interrupt from the processor. It then writes the control register (acknowledging that interrupt), loads the address register, moves the data word, and writes the control register again with the bit that interrupts the processor. A read returns its word with a one-cycle done pulse.

The byte-cycle timing is set as counts of the block's clock: setup before the strobe, strobe low time, and hold after the strobe. The parameter `LOW_FIRST` picks which byte of an address or data word travels in the first byte cycle.

Top module: `hport_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, chip select and both strobes are high (inactive), `cmd_ready` is low and `rsp_done` is low.
- R2: After reset the block performs one control-register write of two byte cycles before anything else. The control byte has bit 2 (interrupt clear) set, bit 1 (interrupt raise) clear, and bit 0 equal to `LOW_FIRST`. Bit 0 = 1 means the low byte goes in the first byte cycle. Both byte cycles carry this byte.
- R3: Each byte cycle holds chip select low for `SETUP_CYC` cycles before the strobe, exactly `STROBE_CYC` cycles of strobe low, and `HOLD_CYC` cycles after it. Select, byte-half and output data stay stable while a strobe is low, and at most one strobe is low at a time.
- R4: Each command runs eight byte cycles in this order: control, control, address, address, data, data, control, control. The select codes are control = 00, address = 10 and data = 11. Byte-half is 0 on the first cycle of each pair and 1 on the second. Only the two data cycles of a read command use the read strobe.
- R5: With `LOW_FIRST` = 1, the first address cycle and the first data cycle carry bits 7:0 of the word and the second cycles carry bits 15:8. With `LOW_FIRST` = 0 the order is reversed.
- R6: No byte cycle of an accepted command starts until `proc_irq` has been sampled high on `IRQ_SAMPLES` consecutive rising edges. A high pulse that lasts one cycle starts nothing.
- R7: The first control byte of a command has the clear bit (bit 2) set and the raise bit (bit 1) clear. The last control pair has the raise bit set, so the processor is interrupted exactly once per command, after the data cycles.
- R8: `cmd_ready` is low until the initialization write has finished and whenever a command is in progress. It is never high while chip select is low. A command is accepted on a rising edge with `cmd_valid` and `cmd_ready` both high.
- R9: `rsp_done` is high for exactly one cycle per command. For a read, `rsp_rdata` then holds the word assembled from the two data read cycles according to R5.
- R10: When `proc_irq` is already qualified, `rsp_done` rises `1 + 8*(SETUP_CYC+STROBE_CYC+HOLD_CYC+2)` rising edges after the accepting edge. With the default parameters this is 81 edges.
- R11: A write command delivers `cmd_wdata` to the processor's data register at address `cmd_addr`, split into bytes as in R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command can be taken |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 16 | Processor memory address |
| cmd_wdata | input | 16 | Word to write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Word read, valid with rsp_done |
| proc_irq | input | 1 | Data-ready interrupt from the processor |
| port_cs_n | output | 1 | Port chip select, active low |
| port_rd_n | output | 1 | Read strobe, active low |
| port_wr_n | output | 1 | Write strobe, active low |
| port_sel | output | 2 | Register select: 00 control, 10 address, 11 data |
| port_half | output | 1 | 0 on first byte cycle, 1 on second |
| port_dout | output | 8 | Byte driven toward the port |
| port_din | input | 8 | Byte returned by the port |

## Verification
One byte cycle costs `SETUP_CYC+STROBE_CYC+HOLD_CYC+2` clock edges, which is 10 by default. The initialization pair therefore ends 20 edges after reset release. A command whose interrupt is already qualified completes 81 edges after acceptance. A command that has to wait for the interrupt completes 82 edges after the interrupt rises, because of the two-sample qualification. The bench counts rising edges from the accepting edge (or from the interrupt rise) and samples every output at the falling edge after each counted edge. It compares the count with these formulas and checks the done pulse one falling edge later. The bench's processor model logs each strobe with its select, byte-half and data, and measures the strobe width in nanoseconds. It then compares the eight-entry log of each command against the expected script and byte order.

// File: rtl/hport_pkg.sv
package hport_pkg;

    localparam int WORD_W     = 16;
    localparam int BYTE_W     = 8;
    localparam int STEPS      = 8;   // byte cycles per command
    localparam int INIT_STEPS = 2;   // byte cycles of the start-up control write

    // control byte fields
    localparam int CTL_ORDER  = 0;   // 1: low byte in first cycle
    localparam int CTL_RAISE  = 1;   // interrupt toward the processor
    localparam int CTL_CLEAR  = 2;   // clear processor-to-host interrupt

    typedef enum logic [1:0] {
        SEL_CTRL = 2'b00,
        SEL_ADDR = 2'b10,
        SEL_DATA = 2'b11
    } reg_sel_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    typedef enum logic [2:0] {
        SQ_INIT,
        SQ_IDLE,
        SQ_WAIT,
        SQ_RUN,
        SQ_DONE
    } seq_e;

endpackage

// File: rtl/hport_irq_filter.sv
module hport_irq_filter #(
    parameter int SAMPLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq,
    output logic valid
);

    generate
        if (SAMPLES <= 1) begin : g_direct
            assign valid = irq;
        end else begin : g_hist
            localparam int HW = SAMPLES - 1;
            logic [HW-1:0] hist_d, hist_q;

            always_comb begin
                hist_d = HW'({hist_q, irq});
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) hist_q <= '0;
                else        hist_q <= hist_d;
            end

            assign valid = irq & (&hist_q);
        end
    endgenerate

endmodule

// File: rtl/hport_byte_engine.sv
module hport_byte_engine
    import hport_pkg::*;
#(
    parameter int SETUP_CYC  = 2,
    parameter int STROBE_CYC = 4,
    parameter int HOLD_CYC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_read,
    input  logic [1:0]        sel_in,
    input  logic              half_in,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [BYTE_W-1:0] bus_din,
    output logic              idle,
    output logic              done,
    output logic [BYTE_W-1:0] rbyte,
    output logic              cs_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [1:0]        sel,
    output logic              half,
    output logic [BYTE_W-1:0] dout
);

    localparam int MAX_AB = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
    localparam int MAXC   = (MAX_AB > HOLD_CYC) ? MAX_AB : HOLD_CYC;
    localparam int CW     = $clog2(MAXC + 1);
    localparam logic [CW-1:0] SETUP_LAST  = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] STROBE_LAST = CW'(STROBE_CYC - 1);
    localparam logic [CW-1:0] HOLD_LAST   = CW'(HOLD_CYC - 1);

    typedef struct packed {
        phase_e            ph;
        logic [CW-1:0]     cnt;
        logic              rd;
        logic [1:0]        sel;
        logic              half;
        logic [BYTE_W-1:0] byt;
        logic              done;
        logic [BYTE_W-1:0] rbyte;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.ph)
            PH_IDLE: begin
                if (start) begin
                    d.ph   = PH_SETUP;
                    d.cnt  = '0;
                    d.rd   = op_read;
                    d.sel  = sel_in;
                    d.half = half_in;
                    d.byt  = byte_in;
                end
            end
            PH_SETUP: begin
                if (q.cnt == SETUP_LAST) begin
                    d.ph  = PH_STROBE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            PH_STROBE: begin
                if (q.cnt == STROBE_LAST) begin
                    d.ph  = PH_HOLD;
                    d.cnt = '0;
                    if (q.rd) d.rbyte = bus_din;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            PH_HOLD: begin
                if (q.cnt == HOLD_LAST) begin
                    d.ph   = PH_IDLE;
                    d.cnt  = '0;
                    d.done = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ph    <= PH_IDLE;
            q.cnt   <= '0;
            q.rd    <= 1'b0;
            q.sel   <= 2'b00;
            q.half  <= 1'b0;
            q.byt   <= '0;
            q.done  <= 1'b0;
            q.rbyte <= '0;
        end else begin
            q <= d;
        end
    end

    assign idle  = (q.ph == PH_IDLE);
    assign done  = q.done;
    assign rbyte = q.rbyte;
    assign cs_n  = (q.ph == PH_IDLE);
    assign rd_n  = !((q.ph == PH_STROBE) && q.rd);
    assign wr_n  = !((q.ph == PH_STROBE) && !q.rd);
    assign sel   = q.sel;
    assign half  = q.half;
    assign dout  = q.byt;

endmodule

// File: rtl/hport_seq.sv
module hport_seq
    import hport_pkg::*;
#(
    parameter int SETUP_CYC   = 2,
    parameter int STROBE_CYC  = 4,
    parameter int HOLD_CYC    = 2,
    parameter bit LOW_FIRST   = 1'b0,
    parameter int IRQ_SAMPLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [WORD_W-1:0] cmd_addr,
    input  logic [WORD_W-1:0] cmd_wdata,
    output logic              rsp_done,
    output logic [WORD_W-1:0] rsp_rdata,
    input  logic              proc_irq,
    output logic              port_cs_n,
    output logic              port_rd_n,
    output logic              port_wr_n,
    output logic [1:0]        port_sel,
    output logic              port_half,
    output logic [BYTE_W-1:0] port_dout,
    input  logic [BYTE_W-1:0] port_din
);

    localparam int SW = $clog2(STEPS);
    localparam logic [SW-1:0] LAST_STEP = SW'(STEPS - 1);
    localparam logic [SW-1:0] INIT_LAST = SW'(INIT_STEPS - 1);

    typedef struct packed {
        seq_e              st;
        logic [SW-1:0]     step;
        logic              issued;
        logic              wr;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
        logic [WORD_W-1:0] rdata;
    } seq_t;

    seq_t q, d;

    logic              irq_ok;
    logic              eng_idle, eng_done, eng_start;
    logic [BYTE_W-1:0] eng_rbyte;
    reg_sel_e          step_sel;
    logic              pick_low;
    logic              step_read;
    logic [BYTE_W-1:0] ctl_byte;
    logic [WORD_W-1:0] step_word;
    logic [BYTE_W-1:0] step_byte;

    hport_irq_filter #(
        .SAMPLES(IRQ_SAMPLES)
    ) u_irq (
        .clk  (clk),
        .rst_n(rst_n),
        .irq  (proc_irq),
        .valid(irq_ok)
    );

    // decode of the current script step
    always_comb begin
        case (q.step[SW-1:1])
            2'd1:    step_sel = SEL_ADDR;
            2'd2:    step_sel = SEL_DATA;
            default: step_sel = SEL_CTRL;
        endcase
        pick_low  = q.step[0] ^ LOW_FIRST;
        step_read = (step_sel == SEL_DATA) && !q.wr;

        ctl_byte            = '0;
        ctl_byte[CTL_ORDER] = LOW_FIRST;
        if ((q.st == SQ_INIT) || (q.step[SW-1:1] == 2'd0))
            ctl_byte[CTL_CLEAR] = 1'b1;
        else
            ctl_byte[CTL_RAISE] = 1'b1;

        step_word = (step_sel == SEL_ADDR) ? q.addr : q.wdata;
        if (step_sel == SEL_CTRL)
            step_byte = ctl_byte;
        else if (pick_low)
            step_byte = step_word[BYTE_W-1:0];
        else
            step_byte = step_word[WORD_W-1:BYTE_W];

        eng_start = ((q.st == SQ_INIT) || (q.st == SQ_RUN)) && !q.issued && eng_idle;
    end

    // next-state computation
    always_comb begin
        d = q;
        if (eng_start) d.issued = 1'b1;
        case (q.st)
            SQ_INIT, SQ_RUN: begin
                if (eng_done) begin
                    d.issued = 1'b0;
                    d.step   = q.step + 1'b1;
                    if (step_read) begin
                        if (pick_low) d.rdata[BYTE_W-1:0]      = eng_rbyte;
                        else          d.rdata[WORD_W-1:BYTE_W] = eng_rbyte;
                    end
                    if ((q.st == SQ_INIT) && (q.step == INIT_LAST)) begin
                        d.st   = SQ_IDLE;
                        d.step = '0;
                    end else if ((q.st == SQ_RUN) && (q.step == LAST_STEP)) begin
                        d.st   = SQ_DONE;
                        d.step = '0;
                    end
                end
            end
            SQ_IDLE: begin
                if (cmd_valid) begin
                    d.st    = SQ_WAIT;
                    d.wr    = cmd_write;
                    d.addr  = cmd_addr;
                    d.wdata = cmd_wdata;
                    d.rdata = '0;
                end
            end
            SQ_WAIT: begin
                if (irq_ok) begin
                    d.st   = SQ_RUN;
                    d.step = '0;
                end
            end
            SQ_DONE: d.st = SQ_IDLE;
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= SQ_INIT;
            q.step   <= '0;
            q.issued <= 1'b0;
            q.wr     <= 1'b0;
            q.addr   <= '0;
            q.wdata  <= '0;
            q.rdata  <= '0;
        end else begin
            q <= d;
        end
    end

    hport_byte_engine #(
        .SETUP_CYC (SETUP_CYC),
        .STROBE_CYC(STROBE_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (eng_start),
        .op_read(step_read),
        .sel_in (step_sel),
        .half_in(q.step[0]),
        .byte_in(step_byte),
        .bus_din(port_din),
        .idle   (eng_idle),
        .done   (eng_done),
        .rbyte  (eng_rbyte),
        .cs_n   (port_cs_n),
        .rd_n   (port_rd_n),
        .wr_n   (port_wr_n),
        .sel    (port_sel),
        .half   (port_half),
        .dout   (port_dout)
    );

    assign cmd_ready = (q.st == SQ_IDLE);
    assign rsp_done  = (q.st == SQ_DONE);
    assign rsp_rdata = q.rdata;

endmodule

// File: rtl/hport_seq_chk.sv
module hport_seq_chk #(
    parameter int STROBE_CYC = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_ready,
    input logic       rsp_done,
    input logic       port_cs_n,
    input logic       port_rd_n,
    input logic       port_wr_n,
    input logic [1:0] port_sel,
    input logic       port_half,
    input logic [7:0] port_dout
);

    logic        strobe_act;
    logic [15:0] low_cnt;

    assign strobe_act = !port_rd_n || !port_wr_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          low_cnt <= '0;
        else if (strobe_act) low_cnt <= low_cnt + 16'd1;
        else                 low_cnt <= '0;
    end

    AST_STROBE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_act |-> !port_cs_n) else $error("strobe outside chip select"); // R3

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!port_rd_n && !port_wr_n)) else $error("both strobes low"); // R3

    AST_BUS_STABLE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_act && $past(strobe_act)) |->
            ($stable(port_sel) && $stable(port_half) && $stable(port_dout)))
        else $error("bus moved during strobe"); // R3

    AST_HOLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_act) |-> !port_cs_n) else $error("no hold after strobe"); // R3

    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_act) |-> (low_cnt == 16'(STROBE_CYC)))
        else $error("strobe width wrong"); // R3

    AST_READY_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !port_cs_n |-> !cmd_ready) else $error("ready during bus activity"); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done) else $error("done longer than one cycle"); // R9

    AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !cmd_ready) else $error("done while ready"); // R8

endmodule

bind hport_seq hport_seq_chk #(
    .STROBE_CYC(STROBE_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_ready(cmd_ready),
    .rsp_done (rsp_done),
    .port_cs_n(port_cs_n),
    .port_rd_n(port_rd_n),
    .port_wr_n(port_wr_n),
    .port_sel (port_sel),
    .port_half(port_half),
    .port_dout(port_dout)
);

// File: tb/sim_hport_seq.sv
`timescale 1ns/1ps
module sim_hport_seq;

    localparam int SU = 2, ST = 4, HO = 2;
    localparam bit LF = 1'b1;
    localparam int BYTE_CYC = SU + ST + HO + 2;
    localparam int CMD_LAT  = 1 + 8 * BYTE_CYC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_write = 1'b0;
    logic        cmd_ready, rsp_done;
    logic [15:0] cmd_addr = '0, cmd_wdata = '0, rsp_rdata;
    logic        proc_irq;
    logic        port_cs_n, port_rd_n, port_wr_n, port_half;
    logic [1:0]  port_sel;
    logic [7:0]  port_dout, port_din;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    hport_seq #(
        .SETUP_CYC(SU), .STROBE_CYC(ST), .HOLD_CYC(HO),
        .LOW_FIRST(LF), .IRQ_SAMPLES(2)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .proc_irq(proc_irq),
        .port_cs_n(port_cs_n), .port_rd_n(port_rd_n), .port_wr_n(port_wr_n),
        .port_sel(port_sel), .port_half(port_half),
        .port_dout(port_dout), .port_din(port_din)
    );

    // ---------------- processor-side model ----------------
    logic [15:0] mem [256];
    logic        order_r = 1'b0;
    logic [7:0]  abyte0 = '0, dbyte0 = '0;
    logic [15:0] areg = '0;
    int          irq_gen = 1;      // boot interrupt pending
    int          irq_ack = 0;
    logic        glitch = 1'b0;
    int          raise_cnt = 0, ctl_cnt = 0;
    int          log_n = 0;
    logic [1:0]  log_sel  [64];
    logic        log_half [64];
    logic        log_rd   [64];
    logic [7:0]  log_byte [64];
    time         t_fall = 0;
    int          bad_wr_w = 0, bad_rd_w = 0;

    assign proc_irq = (irq_gen != irq_ack) || glitch;
    assign port_din = (port_half ^ order_r) ? mem[areg[7:0]][7:0] : mem[areg[7:0]][15:8];

    always @(negedge port_rd_n or negedge port_wr_n) begin
        if (port_cs_n === 1'b0) begin
            log_sel[log_n % 64]  = port_sel;
            log_half[log_n % 64] = port_half;
            log_rd[log_n % 64]   = !port_rd_n;
            log_byte[log_n % 64] = port_dout;
            log_n  = log_n + 1;
            t_fall = $time;
        end
    end

    always @(posedge port_rd_n) begin
        if (port_cs_n === 1'b0 && ($time - t_fall) != ST * 8) bad_rd_w = bad_rd_w + 1;
    end

    always @(posedge port_wr_n) begin
        if (port_cs_n === 1'b0) begin
            if (($time - t_fall) != ST * 8) bad_wr_w = bad_wr_w + 1;
            case (port_sel)
                2'b00: begin
                    ctl_cnt = ctl_cnt + 1;
                    order_r = port_dout[0];
                    if (port_dout[2]) irq_ack = irq_gen;
                    if (port_dout[1] && port_half) raise_cnt = raise_cnt + 1;
                end
                2'b10: begin
                    if (!port_half) abyte0 = port_dout;
                    else areg = order_r ? {port_dout, abyte0} : {abyte0, port_dout};
                end
                2'b11: begin
                    if (!port_half) dbyte0 = port_dout;
                    else mem[areg[7:0]] = order_r ? {port_dout, dbyte0} : {dbyte0, port_dout};
                end
                default: ;
            endcase
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] first_b(input logic [15:0] w);
        return LF ? w[7:0] : w[15:8];
    endfunction
    function automatic logic [7:0] second_b(input logic [15:0] w);
        return LF ? w[15:8] : w[7:0];
    endfunction

    // compare the eight logged byte cycles of one command
    task automatic check_script(input int base, input bit wr, input logic [15:0] a, input logic [15:0] w);
        int e_seq = 0, e_ord = 0, e_ctl = 0;
        for (int k = 0; k < 8; k++) begin
            int i = (base + k) % 64;
            logic [1:0] es = (k < 2) ? 2'b00 : (k < 4) ? 2'b10 : (k < 6) ? 2'b11 : 2'b00;
            bit er = (k == 4 || k == 5) && !wr;
            if (log_sel[i] != es || log_half[i] != k[0] || log_rd[i] != er) e_seq++;
        end
        if (log_byte[(base + 2) % 64] != first_b(a))  e_ord++;
        if (log_byte[(base + 3) % 64] != second_b(a)) e_ord++;
        if (wr && log_byte[(base + 4) % 64] != first_b(w))  e_ord++;
        if (wr && log_byte[(base + 5) % 64] != second_b(w)) e_ord++;
        if (log_byte[base % 64] != {5'b0, 1'b1, 1'b0, LF}) e_ctl++;
        if (log_byte[(base + 7) % 64] != {5'b0, 1'b0, 1'b1, LF}) e_ctl++;
        check(log_n == base + 8, "R4 byte-cycle count", log_n - base, 8);
        check(e_seq == 0, "R4 select/half/strobe script", e_seq, 0);
        check(e_ord == 0, "R5 byte order", e_ord, 0);
        check(e_ctl == 0, "R7 clear/raise control bytes", e_ctl, 0);
    endtask

    task automatic do_cmd(input bit wr, input logic [15:0] a, input logic [15:0] w,
                          output logic [15:0] rd);
        int lat = 0, base, r0;
        @(negedge clk); irq_gen++;
        @(negedge clk); @(negedge clk);
        cmd_write = wr; cmd_addr = a; cmd_wdata = w; cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        r0 = raise_cnt;
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
        base = log_n;
        while (!rsp_done && lat < 500) begin
            @(posedge clk); lat++; @(negedge clk);
        end
        rd = rsp_rdata;
        check(lat == CMD_LAT, "R10 completion latency", lat, CMD_LAT);
        check_script(base, wr, a, w);
        check(proc_irq == 1'b0, "R7 ready interrupt cleared", proc_irq, 0);
        check(raise_cnt == r0 + 1, "R7 one raise per command", raise_cnt - r0, 1);
        if (wr) check(mem[a[7:0]] == w, "R11 word delivered", mem[a[7:0]], w);
        @(negedge clk);
        check(rsp_done == 1'b0, "R9 done is one cycle", rsp_done, 0);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [15:0] rd;
        int n;
        int base;
        repeat (3) @(negedge clk);
        check(port_cs_n && port_rd_n && port_wr_n, "R1 bus idle in reset",
              {port_cs_n, port_rd_n, port_wr_n}, 3'b111);
        check(!cmd_ready && !rsp_done, "R1 ready/done low in reset", {cmd_ready, rsp_done}, 0);

        // release reset with a command already pending
        rst_n = 1'b1;
        cmd_write = 1'b1; cmd_addr = 16'h0A80; cmd_wdata = 16'h5AC3; cmd_valid = 1'b1;
        check(port_cs_n && !cmd_ready, "R1 first cycle after reset", {port_cs_n, cmd_ready}, 2'b10);
        n = 0;
        while (!cmd_ready && n < 200) begin
            @(posedge clk); n++; @(negedge clk);
        end
        check(n == 2 * BYTE_CYC, "R8 ready held low during start-up", n, 2 * BYTE_CYC);
        check(log_n == 2 && ctl_cnt == 2, "R2 start-up writes", log_n, 2);
        check(log_sel[0] == 2'b00 && log_sel[1] == 2'b00 && !log_half[0] && log_half[1],
              "R2 start-up select/half", {log_sel[0], log_sel[1]}, 0);
        check(log_byte[0] == {5'b0, 3'b100 | {2'b0, LF}} && log_byte[1] == log_byte[0],
              "R2 start-up control byte", log_byte[1], {5'b0, 3'b100 | {2'b0, LF}});
        check(proc_irq == 1'b0, "R2 boot interrupt cleared", proc_irq, 0);
        check(order_r == LF, "R2 byte-order bit", order_r, LF);

        // pending command is accepted but must wait for the interrupt
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
        base = log_n;
        repeat (30) @(negedge clk);
        check(log_n == base && port_cs_n && !rsp_done, "R6 no access without interrupt", log_n - base, 0);
        glitch = 1'b1; @(negedge clk); glitch = 1'b0;
        repeat (10) @(negedge clk);
        check(log_n == base && port_cs_n, "R6 single-cycle pulse ignored", log_n - base, 0);
        irq_gen++;
        n = 0;
        while (!rsp_done && n < 500) begin
            @(posedge clk); n++; @(negedge clk);
        end
        check(n == CMD_LAT + 1, "R6 start after qualified interrupt", n, CMD_LAT + 1);
        check_script(base, 1'b1, 16'h0A80, 16'h5AC3);
        check(mem[8'h80] == 16'h5AC3, "R11 pending write delivered", mem[8'h80], 16'h5AC3);

        // sweep: writes then reads over 16 addresses
        for (int a = 0; a < 16; a++) begin
            logic [15:0] ad = {a[7:0], 8'(a * 17)};
            logic [15:0] pat = 16'(a * 16'h1357) ^ 16'hA5C3;
            do_cmd(1'b1, ad, pat, rd);
        end
        for (int a = 15; a >= 0; a--) begin
            logic [15:0] ad = {a[7:0] ^ 8'hFF, 8'(a * 17)};
            logic [15:0] pat = 16'(a * 16'h1357) ^ 16'hA5C3;
            do_cmd(1'b0, ad, 16'h0000, rd);
            check(rd == pat, "R9 read data", rd, pat);
        end
        do_cmd(1'b0, 16'h0A80, 16'h0000, rd);
        check(rd == 16'h5AC3, "R9 read of first write", rd, 16'h5AC3);

        check(bad_wr_w == 0 && bad_rd_w == 0, "R3 strobe width", bad_wr_w + bad_rd_w, 0);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule